// File: doc/BRIEF.md
# GPIO and Pin Crossbar Register Bank

This block is a byte-wide register file that owns up to 128 general-purpose I/O lines. Each line has a control register holding its output-enable and output-data latches and showing its synchronized input level. Each line also has a crossbar register that picks what drives the pad: either the GPIO latches, or one of a set of internal peripheral output/enable pairs. The same output-data, output-enable and input bits are also reachable packed eight lines to a byte through bank registers. The bank registers are a second window onto the same latches, not separate storage. Three read-only identification registers report a model number and a revision constant.

The bus is a simple synchronous register port. A cycle with `bus_sel` high and `bus_we` high is a write. A cycle with `bus_sel` high and `bus_we` low is a read. The block accepts one access per clock and never stalls, so there is no back-pressure. Read data is registered and is qualified by `bus_rvalid` in the following cycle. The pad outputs are combinational from the latches and the peripheral inputs. A latch write therefore reaches the pad right after the clock edge that performs it.

Top module: `gpio_xbar_regs`

## Requirements
- R1: After reset, every output-enable latch, every output-data latch and every crossbar register is zero. The crossbar registers therefore select peripheral source 0 with GPIO mode off.
- R2: A read presented in one cycle returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle. `bus_rvalid` is low in the cycle after any write or idle cycle. Back-to-back accesses are accepted every cycle.
- R3: The per-line register for line n is at address n, for n from 0 to 127. Bit 0 is output enable, bit 1 is output data and bit 2 is the synchronized input; bits 7:3 read zero. A write loads bit 0 into the enable latch and bit 1 into the data latch.
- R4: The crossbar register for line n is at address 128+n and reads back all eight written bits. Bit 7 is GPIO mode and bits 6:0 are the source index.
- R5: The input banks are at 256+b, the data banks at 272+b and the enable banks at 288+b. Line n sits in bank n/8 at bit n%8. A bank write updates the same latches as a per-line write, so either view reads the new value next. Writes to input banks are ignored.
- R6: With crossbar bit 7 set, the pad output equals the line's data latch and the pad enable equals its enable latch. An enable of 1 means the pad drives.
- R7: With crossbar bit 7 clear, the pad output and enable follow peripheral source k = bits 6:0 when k < NUM_SRC. When k >= NUM_SRC, the pad output is 0 and the pad enable is 0.
- R8: Pad inputs pass through two flops. A read sampled at the first or second clock edge after an input change returns the old level. A read sampled at the third edge returns the new level.
- R9: Address 304 reads 0x41, address 305 reads 0x00 and address 306 reads the REV parameter. Writes to these addresses have no effect.
- R10: All other addresses read zero, and writes to them are ignored. This covers 307 and up, and the per-line, crossbar and bank bits of lines at or beyond NUM_PINS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pad_in | input | NUM_PINS | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables, 1 = drive |
| periph_out | input | NUM_SRC | Peripheral output signals for the crossbar |
| periph_oe | input | NUM_SRC | Peripheral output enables for the crossbar |

## Verification
The bench builds the block with NUM_PINS = 12, NUM_SRC = 5 and REV = 0x12. Twelve lines leave the second bank half filled. This shows that bank bits and per-line registers for missing lines read zero and drop writes. With only five sources, both the last valid index (4) and the first invalid one (5) can be exercised, along with an index far out of range (127).

// File: rtl/gxb_pkg.sv
package gxb_pkg;
  localparam int MAX_PINS = 128;

  typedef enum logic [3:0] {
    RG_PIN, RG_XBAR, RG_INB, RG_DATB, RG_OEB, RG_ID_HI, RG_ID_LO, RG_REV, RG_NONE
  } region_t;

  function automatic region_t addr_region(input logic [15:0] a);
    if (a < 16'd128)       return RG_PIN;
    else if (a < 16'd256)  return RG_XBAR;
    else if (a < 16'd272)  return RG_INB;
    else if (a < 16'd288)  return RG_DATB;
    else if (a < 16'd304)  return RG_OEB;
    else if (a == 16'd304) return RG_ID_HI;
    else if (a == 16'd305) return RG_ID_LO;
    else if (a == 16'd306) return RG_REV;
    else                   return RG_NONE;
  endfunction
endpackage

// File: rtl/gxb_sync.sv
module gxb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gxb_store.sv
module gxb_store import gxb_pkg::*; #(
  parameter int NUM_PINS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  region_t                  region,
  input  logic [6:0]               addr_lo,
  input  logic [7:0]               wdata,
  output logic [NUM_PINS-1:0]      oe_q,
  output logic [NUM_PINS-1:0]      dat_q,
  output logic [NUM_PINS-1:0][7:0] xbar_q
);
  // One latch set per implemented line; lines past NUM_PINS have no storage.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
    localparam logic [6:0] IDX = 7'(i);
    localparam logic [3:0] BK  = 4'(i / 8);
    localparam int         BT  = i % 8;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_q[i]   <= 1'b0;
        dat_q[i]  <= 1'b0;
        xbar_q[i] <= 8'h00;
      end else if (wr_en) begin
        case (region)
          RG_PIN:  if (addr_lo == IDX) begin
                     oe_q[i]  <= wdata[0];
                     dat_q[i] <= wdata[1];
                   end
          RG_XBAR: if (addr_lo == IDX) xbar_q[i] <= wdata;
          RG_DATB: if (addr_lo[3:0] == BK) dat_q[i] <= wdata[BT];
          RG_OEB:  if (addr_lo[3:0] == BK) oe_q[i]  <= wdata[BT];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gxb_rdmux.sv
module gxb_rdmux import gxb_pkg::*; #(
  parameter logic [7:0] REV = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  region_t                  region,
  input  logic [6:0]               addr_lo,
  input  logic [MAX_PINS-1:0]      in_v,
  input  logic [MAX_PINS-1:0]      dat_v,
  input  logic [MAX_PINS-1:0]      oe_v,
  input  logic [MAX_PINS-1:0][7:0] xbar_v,
  output logic [7:0]               rdata,
  output logic                     rvalid
);
  logic [6:0] bank_base;
  logic [7:0] rd_next;

  assign bank_base = {addr_lo[3:0], 3'b000};

  always_comb begin
    case (region)
      RG_PIN:   rd_next = {5'b0, in_v[addr_lo], dat_v[addr_lo], oe_v[addr_lo]};
      RG_XBAR:  rd_next = xbar_v[addr_lo];
      RG_INB:   rd_next = in_v[bank_base +: 8];
      RG_DATB:  rd_next = dat_v[bank_base +: 8];
      RG_OEB:   rd_next = oe_v[bank_base +: 8];
      RG_ID_HI: rd_next = 8'h41;
      RG_ID_LO: rd_next = 8'h00;
      RG_REV:   rd_next = REV;
      default:  rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/gxb_pad_mux.sv
module gxb_pad_mux import gxb_pkg::*; #(
  parameter int NUM_SRC = 16
) (
  input  logic [7:0]         xsel,
  input  logic               gpio_dat,
  input  logic               gpio_oe,
  input  logic [NUM_SRC-1:0] src_out,
  input  logic [NUM_SRC-1:0] src_oe,
  output logic               pad_out,
  output logic               pad_oe
);
  logic [MAX_PINS-1:0] so_w, se_w;
  logic                src_ok;

  assign so_w   = MAX_PINS'(src_out);
  assign se_w   = MAX_PINS'(src_oe);
  assign src_ok = int'(xsel[6:0]) < NUM_SRC;

  always_comb begin
    if (xsel[7]) begin
      pad_out = gpio_dat;
      pad_oe  = gpio_oe;
    end else begin
      pad_out = src_ok & so_w[xsel[6:0]];
      pad_oe  = src_ok & se_w[xsel[6:0]];
    end
  end
endmodule

// File: rtl/gpio_xbar_regs.sv
module gpio_xbar_regs import gxb_pkg::*; #(
  parameter int         NUM_PINS = 128,
  parameter int         NUM_SRC  = 16,
  parameter logic [7:0] REV      = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [15:0]         bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_SRC-1:0]  periph_out,
  input  logic [NUM_SRC-1:0]  periph_oe
);
  region_t                    region;
  logic [NUM_PINS-1:0]        in_sync;
  logic [NUM_PINS-1:0]        oe_q, dat_q;
  logic [NUM_PINS-1:0][7:0]   xbar_q;
  logic [MAX_PINS-1:0]        in_v, oe_v, dat_v;
  logic [MAX_PINS-1:0][7:0]   xbar_v;

  assign region = addr_region(bus_addr);

  gxb_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );

  gxb_store #(.NUM_PINS(NUM_PINS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_sel && bus_we), .region(region),
    .addr_lo(bus_addr[6:0]), .wdata(bus_wdata),
    .oe_q(oe_q), .dat_q(dat_q), .xbar_q(xbar_q)
  );

  // Full-width views; lines past NUM_PINS read as zero.
  for (genvar i = 0; i < MAX_PINS; i++) begin : g_view
    if (i < NUM_PINS) begin : g_live
      assign in_v[i]   = in_sync[i];
      assign oe_v[i]   = oe_q[i];
      assign dat_v[i]  = dat_q[i];
      assign xbar_v[i] = xbar_q[i];
    end else begin : g_absent
      assign in_v[i]   = 1'b0;
      assign oe_v[i]   = 1'b0;
      assign dat_v[i]  = 1'b0;
      assign xbar_v[i] = 8'h00;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
    gxb_pad_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .xsel(xbar_q[i]), .gpio_dat(dat_q[i]), .gpio_oe(oe_q[i]),
      .src_out(periph_out), .src_oe(periph_oe),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
    );
  end

  gxb_rdmux #(.REV(REV)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_sel && !bus_we), .region(region),
    .addr_lo(bus_addr[6:0]), .in_v(in_v), .dat_v(dat_v), .oe_v(oe_v),
    .xbar_v(xbar_v), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );
endmodule

// File: rtl/gxb_check.sv
module gxb_check #(
  parameter int         NUM_PINS = 128,
  parameter int         NUM_SRC  = 16,
  parameter logic [7:0] REV      = 8'h01
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_we,
  input logic [15:0]              bus_addr,
  input logic                     wd0,
  input logic [7:0]               bus_rdata,
  input logic                     bus_rvalid,
  input logic [NUM_PINS-1:0]      pad_out,
  input logic [NUM_PINS-1:0]      pad_oe,
  input logic [NUM_PINS-1:0]      oe_q,
  input logic [NUM_PINS-1:0]      dat_q,
  input logic [NUM_PINS-1:0][7:0] xbar_q
);
  logic rd, wr;
  assign rd = bus_sel && !bus_we;
  assign wr = bus_sel && bus_we;

  assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  assert_no_rvalid_otherwise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);
  assert_pin_reserved_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr < 16'd128) |=> bus_rdata[7:3] == 5'b0);
  assert_bank_write_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 16'd272) |=> dat_q[0] == $past(wd0));
  assert_id_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 16'd304) |=> bus_rdata == 8'h41);
  assert_revision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 16'd306) |=> bus_rdata == REV);
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr >= 16'd307) |=> bus_rdata == 8'h00);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assert_gpio_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xbar_q[i][7] |-> (pad_out[i] == dat_q[i] && pad_oe[i] == oe_q[i]));
    assert_bad_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!xbar_q[i][7] && int'(xbar_q[i][6:0]) >= NUM_SRC) |-> (!pad_out[i] && !pad_oe[i]));
  end
endmodule

bind gpio_xbar_regs gxb_check #(.NUM_PINS(NUM_PINS), .NUM_SRC(NUM_SRC), .REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .wd0(bus_wdata[0]), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .pad_out(pad_out), .pad_oe(pad_oe), .oe_q(oe_q), .dat_q(dat_q), .xbar_q(xbar_q)
);

// File: tb/test_gpio_xbar_regs.sv
`timescale 1ns/1ps
module test_gpio_xbar_regs;
  localparam int         NP = 12;
  localparam int         NS = 5;
  localparam logic [7:0] RV = 8'h12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NS-1:0] periph_out = '0, periph_oe = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  exp_q[$];
  logic [15:0] adr_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gpio_xbar_regs #(.NUM_PINS(NP), .NUM_SRC(NS), .REV(RV)) i_gpio_xbar_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_oe(periph_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: each access occupies one cycle, starting and ending at a falling edge.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); adr_q.push_back(a); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Monitor: pops one expectation per returned read.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: unexpected rvalid, actual %0h expected none", bus_rdata);
      end else begin
        automatic logic [7:0]  e = exp_q.pop_front();
        automatic logic [15:0] a = adr_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check($sformatf("%s read addr %0d", t, a), 32'(bus_rdata), 32'(e));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
    check("R1 pad_out after reset", 32'(pad_out), 32'h0);
    rd(16'd0, 8'h00, "R1");
    rd(16'd128, 8'h00, "R1");
    rd(16'd272, 8'h00, "R1");
    rd(16'd288, 8'h00, "R1");
    periph_out = 5'b00001; periph_oe = 5'b00001;
    #1;
    check("R7 all lines on source 0 out", 32'(pad_out), 32'hFFF);
    check("R7 all lines on source 0 oe", 32'(pad_oe), 32'hFFF);
    @(negedge clk);
    // R3 per-line register
    wr(16'd3, 8'hFF);
    rd(16'd3, 8'h03, "R3");
    // R6 GPIO mode
    wr(16'd131, 8'h80);
    check("R6 gpio out", 32'(pad_out[3]), 32'h1);
    check("R6 gpio oe", 32'(pad_oe[3]), 32'h1);
    wr(16'd3, 8'h01);
    check("R6 gpio out low", 32'(pad_out[3]), 32'h0);
    check("R6 gpio oe kept", 32'(pad_oe[3]), 32'h1);
    wr(16'd3, 8'h02);
    check("R6 gpio out high", 32'(pad_out[3]), 32'h1);
    check("R6 gpio oe off", 32'(pad_oe[3]), 32'h0);
    check("R2 no rvalid after write", 32'(bus_rvalid), 32'h0);
    // R4 crossbar readback
    rd(16'd131, 8'h80, "R4");
    wr(16'd130, 8'h7F);
    rd(16'd130, 8'h7F, "R4");
    // R7 peripheral selection
    check("R7 source 127 out", 32'(pad_out[2]), 32'h0);
    check("R7 source 127 oe", 32'(pad_oe[2]), 32'h0);
    periph_out = 5'b10001; periph_oe = 5'b10001;
    wr(16'd132, 8'h04);
    check("R7 source 4 out", 32'(pad_out[4]), 32'h1);
    check("R7 source 4 oe", 32'(pad_oe[4]), 32'h1);
    periph_out = 5'b00001;
    #1;
    check("R7 source 4 follows", 32'(pad_out[4]), 32'h0);
    @(negedge clk);
    wr(16'd132, 8'h05);
    check("R7 source 5 out", 32'(pad_out[4]), 32'h0);
    check("R7 source 5 oe", 32'(pad_oe[4]), 32'h0);
    // R5 bank aliasing
    wr(16'd272, 8'hA5);
    rd(16'd5, 8'h02, "R5");
    rd(16'd272, 8'hA5, "R5");
    wr(16'd289, 8'hFF);
    rd(16'd289, 8'h0F, "R5");
    rd(16'd8, 8'h01, "R5");
    rd(16'd273, 8'h00, "R5");
    wr(16'd256, 8'hFF);
    rd(16'd256, 8'h00, "R5");
    wr(16'd0, 8'h00);
    wr(16'd7, 8'h01);
    rd(16'd272, 8'h24, "R5");
    rd(16'd288, 8'h80, "R5");
    // R8 input synchronizer latency
    pad_in = 12'h8C5;
    rd(16'd256, 8'h00, "R8");
    @(negedge clk);
    rd(16'd256, 8'hC5, "R8");
    rd(16'd257, 8'h08, "R8");
    rd(16'd11, 8'h05, "R8");
    rd(16'd0, 8'h04, "R8");
    // R9 identification
    rd(16'd304, 8'h41, "R9");
    rd(16'd305, 8'h00, "R9");
    rd(16'd306, RV, "R9");
    wr(16'd306, 8'hFF);
    wr(16'd304, 8'h00);
    rd(16'd306, RV, "R9");
    rd(16'd304, 8'h41, "R9");
    // R10 reserved and absent lines
    wr(16'd12, 8'hFF);
    rd(16'd12, 8'h00, "R10");
    wr(16'd140, 8'hFF);
    rd(16'd140, 8'h00, "R10");
    wr(16'd307, 8'hFF);
    rd(16'd307, 8'h00, "R10");
    rd(16'hFFFF, 8'h00, "R10");
    rd(16'd258, 8'h00, "R10");
    rd(16'd274, 8'h00, "R10");
    rd(16'd303, 8'h00, "R10");
    repeat (3) @(negedge clk);
    check("R2 all reads returned", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule